// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The bimodal component keeps one 2-bit saturating counter per PC slot. The gshare component keeps a second table of counters, indexed by the PC slot bits XORed with a global record of recent branch outcomes. A third table of 2-bit chooser counters, indexed by the PC slot bits, decides for each branch which component's guess becomes the final answer.

The fetch stage presents a PC on the predict port. In the same cycle it receives the final guess, both component guesses and the current global history, and it keeps these with the branch. When the branch resolves, the caller returns the PC, the saved history, the saved component guesses and the real outcome on the update port. The block then trains the bimodal and gshare counters the branch used. It adjusts that branch's chooser only when the two components disagreed, and it shifts the outcome into the global history.

Top module: `tourn_pred`

## Requirements
- R1: After reset every counter in all three tables holds 1 (weakly not-taken) and the global history is zero. The first predictions after reset are therefore not-taken from both components, and the final guess is not-taken.
- R2: Each counter holds 0..3 and predicts taken when its value is 2 or 3. A taken update adds one, up to a ceiling of 3. A not-taken update subtracts one, down to a floor of 0.
- R3: The bimodal and chooser tables are indexed by PC bits [11:2]. PC bits [1:0] are the alignment bits and have no effect on which entry is used.
- R4: The gshare table is indexed by PC bits [11:2] XOR the 10-bit global history.
- R5: Each update shifts the actual outcome into bit 0 of the global history (1 = taken), and the older bits move up one place. With no update, the history holds its value. The history is output on `pred_hist`.
- R6: The final guess is the bimodal guess when the chooser counter's bit 1 is 0, and the gshare guess when it is 1.
- R7: The chooser changes only when the supplied component guesses differ. It moves up one (toward gshare) when the gshare guess matched the outcome, and down one (toward bimodal) when the bimodal guess matched.
- R8: An update has no effect on the prediction shown in its own cycle. Its effect is visible from the next cycle on.
- R9: Gshare training uses the caller-supplied history `upd_hist`, not the live global history, to form its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | PC of the branch being predicted |
| pred_taken | output | 1 | Final guess (1 = taken) |
| pred_bim | output | 1 | Bimodal component guess |
| pred_gsh | output | 1 | Gshare component guess |
| pred_hist | output | 10 | Global history used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_hist | input | 10 | History saved at prediction time |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_bim_pred | input | 1 | Bimodal guess saved at prediction time |
| upd_gsh_pred | input | 1 | Gshare guess saved at prediction time |

## Verification
Directed sequences drive one PC through runs of taken and not-taken outcomes. These separate correct saturation at 3 and 0 from wraparound, and they place the threshold crossing in the cycle after the update. A history built bit by bit, paired with a stale `upd_hist`, shows whether gshare trains at the caller's index or at the live one. Chooser sequences alternate agreeing and disagreeing component guesses, which exposes any training on agreement or any move in the wrong direction. Seeded random traffic over a small pool of PCs, some differing only in their alignment bits, then compares every output each cycle against a reference model in the bench.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MAX = 2'd3;
    localparam ctr_t CTR_MIN = 2'd0;
    localparam ctr_t CTR_WEAK_NT = 2'd1;

    // Saturating step of a 2-bit counter; up=1 counts toward taken.
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        ctr_t r;
        if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
        else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
        return r;
    endfunction

    function automatic logic ctr_dir(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
    import tourn_pkg::*;
#(
    parameter int   IDX_W = 10,
    parameter ctr_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_inc
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        ctr_t             val;
    } wr_t;

    ctr_t mem_q [DEPTH];
    wr_t  wr_d;

    always_comb begin
        wr_d     = '0;
        wr_d.en  = upd_en;
        wr_d.idx = upd_idx;
        wr_d.val = ctr_step(mem_q[upd_idx], upd_inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
        end else if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.val;
        end
    end

    assign rd_ctr = mem_q[rd_idx];

    // R2: an increment never leaves the entry at the floor.
    p_inc_off_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && upd_inc |=> mem_q[$past(upd_idx)] != CTR_MIN);
    // R2: a decrement never leaves the entry at the ceiling.
    p_dec_off_ceil_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_inc |=> mem_q[$past(upd_idx)] != CTR_MAX);
    // R2: saturation at the top.
    p_sat_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && upd_inc && mem_q[upd_idx] == CTR_MAX |=> mem_q[$past(upd_idx)] == CTR_MAX);
    // R2: saturation at the bottom.
    p_sat_bot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_inc && mem_q[upd_idx] == CTR_MIN |=> mem_q[$past(upd_idx)] == CTR_MIN);
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.hist = {st_q.hist[HIST_W-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.hist;

    // R5: newest outcome lands in bit 0, older bits move up.
    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(bit_in) && hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));
    // R5: history holds when no outcome arrives.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tourn_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int ALIGN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic             pred_bim,
    output logic             pred_gsh,
    output logic [IDX_W-1:0] pred_hist,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [IDX_W-1:0] upd_hist,
    input  logic             upd_taken,
    input  logic             upd_bim_pred,
    input  logic             upd_gsh_pred
);
    localparam int SLOT_LO = ALIGN_W;
    localparam int SLOT_HI = ALIGN_W + IDX_W - 1;

    typedef struct packed {
        logic [IDX_W-1:0] p_slot;
        logic [IDX_W-1:0] p_gidx;
        logic [IDX_W-1:0] u_slot;
        logic [IDX_W-1:0] u_gidx;
        logic             meta_en;
        logic             meta_up;
    } ctl_t;

    ctl_t ctl_d;
    logic [IDX_W-1:0] ghist;
    ctr_t bim_ctr, gsh_ctr, meta_ctr;

    always_comb begin
        ctl_d         = '0;
        ctl_d.p_slot  = pred_pc[SLOT_HI:SLOT_LO];
        ctl_d.p_gidx  = pred_pc[SLOT_HI:SLOT_LO] ^ ghist;
        ctl_d.u_slot  = upd_pc[SLOT_HI:SLOT_LO];
        ctl_d.u_gidx  = upd_pc[SLOT_HI:SLOT_LO] ^ upd_hist;
        ctl_d.meta_en = upd_valid && (upd_bim_pred != upd_gsh_pred);
        ctl_d.meta_up = (upd_gsh_pred == upd_taken);
    end

    ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_bim (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ctl_d.p_slot), .rd_ctr(bim_ctr),
        .upd_en(upd_valid), .upd_idx(ctl_d.u_slot), .upd_inc(upd_taken)
    );

    ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_gsh (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ctl_d.p_gidx), .rd_ctr(gsh_ctr),
        .upd_en(upd_valid), .upd_idx(ctl_d.u_gidx), .upd_inc(upd_taken)
    );

    ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_meta (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ctl_d.p_slot), .rd_ctr(meta_ctr),
        .upd_en(ctl_d.meta_en), .upd_idx(ctl_d.u_slot), .upd_inc(ctl_d.meta_up)
    );

    ghist_reg #(.HIST_W(IDX_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist)
    );

    assign pred_bim   = ctr_dir(bim_ctr);
    assign pred_gsh   = ctr_dir(gsh_ctr);
    assign pred_taken = ctr_dir(meta_ctr) ? pred_gsh : pred_bim;
    assign pred_hist  = ghist;

    // R6: when the components agree, the final guess cannot differ from them.
    p_agree_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_bim == pred_gsh |-> pred_taken == pred_bim);
    // R6: the final guess always equals one of the component guesses.
    p_final_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == pred_bim || pred_taken == pred_gsh);
endmodule

// File: tb/sim_tourn_pred.sv
module sim_tourn_pred;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [31:0] pred_pc, upd_pc;
    logic [9:0]  upd_hist, pred_hist;
    logic pred_taken, pred_bim, pred_gsh;
    logic upd_valid, upd_taken, upd_bim_pred, upd_gsh_pred;

    always #5 clk = ~clk;

    tourn_pred u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_bim(pred_bim), .pred_gsh(pred_gsh), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
        .upd_taken(upd_taken), .upd_bim_pred(upd_bim_pred), .upd_gsh_pred(upd_gsh_pred)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [1:0] bim_m [1024];
    logic [1:0] gsh_m [1024];
    logic [1:0] meta_m [1024];
    logic [9:0] ghr_m;
    logic [31:0] pool [12];

    function automatic logic [9:0] slot(input logic [31:0] pc);
        return pc[11:2];
    endfunction

    function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: present inputs, compare outputs with the model, clock, train model.
    task automatic cyc(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                       input logic [9:0] uh, input logic ut, input logic ubp, input logic ugp);
        logic eb, eg;
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_hist = uh;
        upd_taken = ut; upd_bim_pred = ubp; upd_gsh_pred = ugp;
        #1;
        eb = bim_m[slot(ppc)][1];
        eg = gsh_m[slot(ppc) ^ ghr_m][1];
        chk("R3 bimodal guess", pred_bim, eb);
        chk("R4 gshare guess", pred_gsh, eg);
        chk("R6 final guess", pred_taken, meta_m[slot(ppc)][1] ? eg : eb);
        chk("R5 history", pred_hist, ghr_m);
        @(posedge clk);
        if (uv) begin
            bim_m[slot(upc)] = step2(bim_m[slot(upc)], ut);
            gsh_m[slot(upc) ^ uh] = step2(gsh_m[slot(upc) ^ uh], ut);
            if (ubp != ugp) meta_m[slot(upc)] = step2(meta_m[slot(upc)], ugp == ut);
            ghr_m = {ghr_m[8:0], ut};
        end
    endtask

    task automatic peek(input logic [31:0] ppc);
        cyc(ppc, 1'b0, 32'h0, 10'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pc, pd, pe, pf;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin bim_m[i] = 2'd1; gsh_m[i] = 2'd1; meta_m[i] = 2'd1; end
        ghr_m = '0;
        rst_n = 1'b0; pred_pc = '0; upd_valid = 0; upd_pc = '0; upd_hist = '0;
        upd_taken = 0; upd_bim_pred = 0; upd_gsh_pred = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        peek(32'h0000_4A10);
        chk("R1 bim after reset", pred_bim, 0);
        chk("R1 gsh after reset", pred_gsh, 0);
        chk("R1 final after reset", pred_taken, 0);
        chk("R1 history after reset", pred_hist, 0);

        // R2: saturation and threshold on one slot (bimodal path)
        pa = 32'h0000_0140;
        for (int i = 0; i < 4; i++) begin
            cyc(pa, 1, pa, ghr_m, 1, 0, 0);
            peek(pa);
            chk("R2 climb", pred_bim, 1);
        end
        begin
            int exp_nt [4] = '{1, 0, 0, 0};
            for (int i = 0; i < 4; i++) begin
                cyc(pa, 1, pa, ghr_m, 0, 0, 0);
                peek(pa);
                chk("R2 descend", pred_bim, exp_nt[i]);
            end
        end
        // one taken from the floor stays not-taken (0 -> 1)
        cyc(pa, 1, pa, ghr_m, 1, 0, 0);
        peek(pa);
        chk("R2 floor no wrap", pred_bim, 0);

        // R3: alignment bits ignored
        peek(pa | 32'h3);
        chk("R3 alignment bits", pred_bim, 0);

        // R8: same-cycle update invisible, next cycle visible
        pd = 32'h0000_0A2C;
        cyc(pd, 1, pd, ghr_m, 1, 0, 0);
        chk("R8 same cycle", pred_bim, 0);
        peek(pd);
        chk("R8 next cycle", pred_bim, 1);

        // R9: gshare trains at caller's history, not the live one
        pe = 32'h0000_0554;            // slot 0x155
        cyc(pe, 1, pe, 10'h2A5, 1, 0, 0);
        cyc(pe, 1, pe, 10'h2A5, 1, 0, 0);
        pf = 32'h0000_0004;            // slot 0x001, trained with history 0
        for (int b = 9; b >= 0; b--) cyc(pf, 1, pf, 10'h000, (10'h2A5 >> b) & 1'b1, 0, 0);
        peek(pe);
        chk("R5 built history", pred_hist, 10'h2A5);
        chk("R9 gshare caller index", pred_gsh, 1);

        // R7: chooser trained only on disagreement
        pc = 32'h0000_0F80;
        cyc(pc, 1, pc, ghr_m, 1, 1, 1);      // agreement: chooser stays at 1
        cyc(pc, 1, pc, ghr_m, 1, 1, 1);
        peek(pc);
        chk("R7 no train on agree", pred_taken, pred_bim);
        chk("R7 chooser model", pred_taken, meta_m[slot(pc)][1] ? gsh_m[slot(pc)^ghr_m][1] : bim_m[slot(pc)][1]);
        cyc(pc, 1, pc, ghr_m, 0, 1, 0);      // gshare right -> up to 2
        peek(pc);
        chk("R7 toward gshare", pred_taken, pred_gsh);
        cyc(pc, 1, pc, ghr_m, 1, 1, 0);      // bimodal right -> down to 1
        peek(pc);
        chk("R7 toward bimodal", pred_taken, pred_bim);

        // Random traffic against the model
        for (int i = 0; i < 12; i++) pool[i] = $urandom & 32'h0000_0FFF;
        pool[11] = pool[10] | 32'h1;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] p, u;
            logic [9:0]  h;
            logic        t, bp, gp;
            p = pool[$urandom_range(0, 11)];
            u = pool[$urandom_range(0, 11)];
            h = ($urandom_range(0, 3) == 0) ? 10'($urandom) : ghr_m;
            t = $urandom_range(0, 2) != 0;
            bp = bim_m[slot(u)][1];
            gp = gsh_m[slot(u) ^ h][1];
            if ($urandom_range(0, 4) == 0) begin bp = $urandom; gp = $urandom; end
            cyc(p, $urandom_range(0, 3) != 0, u, h, t, bp, gp);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule